// File: doc/BRIEF.md
# Stack Transfer Sequencer

This block carries out the stack memory traffic of the control-flow and save/restore operations of an 8-bit processor core: subroutine call and return, software break, return from interrupt, and pushing or pulling the accumulator and the status byte. It owns an 8-bit stack pointer that addresses a fixed 256-byte page at 0x0100. It works through a byte-wide memory port with a request/ready handshake, one byte per accepted cycle.

The core pulses `start` with a 3-bit operation code. It supplies the current program counter, status, accumulator and a jump target. When the last memory access has been accepted, the block raises `done` for one cycle and presents the resulting program counter, status, accumulator and stack pointer. Instruction fetch and the arbitration of hardware interrupts belong to other blocks.

Top module: `stack_seq`

## Requirements
- R1: After reset `sp_out` is 0xFF, `pc_out`, `status_out` and `acc_out` are 0, and `mem_req`, `busy` and `done` are low.
- R2: A push writes to address 0x0100+SP and then decrements SP. A pull increments SP and then reads from 0x0100+SP. SP wraps modulo 256, so a pull from SP=0xFF reads 0x0100 and leaves SP=0x00.
- R3: Operation code 0 (call) pushes PC+2, high byte first and then low byte, and sets `pc_out` to `target_in`.
- R4: Operation code 1 (return from subroutine) pulls the low byte and then the high byte, and sets `pc_out` to that address plus 1, modulo 65536.
- R5: Operation code 2 (break) pushes the high and low bytes of PC+2. It then pushes the status with bit 4 set, reads the low byte at 0xFFFE and the high byte at 0xFFFF, and loads that vector into `pc_out`. `status_out` is the input status with bits 4 and 2 set.
- R6: Operation code 3 (return from interrupt) pulls the status, then the low PC byte, then the high PC byte. `status_out` is the pulled byte unchanged, and `pc_out` is the pulled address with no adjustment.
- R7: Operation code 4 (push accumulator) writes `acc_in`. Status, accumulator and PC are passed through unchanged; every operation other than call, break and the two returns leaves `pc_out` equal to `pc_in`.
- R8: Operation code 5 (pull accumulator) sets `acc_out` to the pulled byte. In `status_out`, bit 7 is set to bit 7 of that byte and bit 1 is set when the byte is zero; the other bits come from `status_in`.
- R9: Operation code 6 (push status) writes `status_in` with bit 4 cleared.
- R10: Operation code 7 (pull status) sets `status_out` to the pulled byte with bit 4 cleared.
- R11: While `mem_req` is high and `mem_ready` is low, the address, write enable and write data stay unchanged. Each cycle with both high completes exactly one access, so the operations make 2, 2, 5, 3, 1, 1, 1 and 1 accesses for codes 0 to 7.
- R12: `done` is high for exactly one cycle, the cycle after the final access is accepted, and the results are valid from that cycle on.
- R13: A `start` that arrives while `busy` is high is ignored. It causes no extra access and no extra `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation when idle |
| op | input | 3 | Operation code (0 to 7) |
| pc_in | input | 16 | Current program counter |
| status_in | input | 8 | Current status byte |
| acc_in | input | 8 | Current accumulator |
| target_in | input | 16 | Jump target for call |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 16 | Access address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Memory accepts the access this cycle |
| pc_out | output | 16 | Resulting program counter |
| status_out | output | 8 | Resulting status |
| acc_out | output | 8 | Resulting accumulator |
| sp_out | output | 8 | Stack pointer |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions check on every cycle that writes land at 0x0100+SP, that each accepted push or pull moves SP by one in the right direction, and that a stalled request holds still. They also check that `done` never lasts two cycles, that vector reads only occur during a break, and that a start while busy leaves the running operation alone. The byte order of each sequence, the return-address offsets, the break-bit masking, the flag update on pulling the accumulator and the SP wrap can only be shown by the bench scenarios. These compare the memory contents and the results against a model of the stack.

// File: rtl/stack_seq_pkg.sv
package stack_seq_pkg;

    typedef enum logic [2:0] {
        OP_CALL  = 3'd0,
        OP_RET   = 3'd1,
        OP_BRK   = 3'd2,
        OP_RTI   = 3'd3,
        OP_PUSHA = 3'd4,
        OP_PULLA = 3'd5,
        OP_PUSHS = 3'd6,
        OP_PULLS = 3'd7
    } seq_op_e;

    typedef enum logic [2:0] {
        DST_NONE,
        DST_LO,
        DST_HI,
        DST_ST,
        DST_ACC
    } dst_e;

    typedef enum logic [1:0] {
        SP_HOLD,
        SP_DEC,
        SP_INC
    } sp_mode_e;

    localparam int FLAG_N = 7;
    localparam int FLAG_B = 4;
    localparam int FLAG_I = 2;
    localparam int FLAG_Z = 1;

    localparam int MAX_STEPS = 5;
    localparam int STEP_W    = $clog2(MAX_STEPS);

    typedef struct packed {
        logic        we;
        sp_mode_e    sp_mode;
        logic [15:0] addr;
        logic [7:0]  wdata;
        dst_e        dst;
        logic        last;
    } access_t;

endpackage

// File: rtl/stack_seq_step.sv
module stack_seq_step
    import stack_seq_pkg::*;
#(
    parameter logic [7:0]  PAGE     = 8'h01,
    parameter logic [15:0] VEC_ADDR = 16'hFFFE
) (
    input  seq_op_e            op,
    input  logic [STEP_W-1:0]  step,
    input  logic [7:0]         sp,
    input  logic [15:0]        pc,
    input  logic [7:0]         st,
    input  logic [7:0]         acc,
    output access_t            acc_o
);

    localparam logic [15:0] VEC_HI_ADDR = VEC_ADDR + 16'd1;

    logic [15:0] ret_addr;
    logic [15:0] push_addr;
    logic [15:0] pull_addr;

    assign ret_addr  = pc + 16'd2;
    assign push_addr = {PAGE, sp};
    assign pull_addr = {PAGE, 8'(sp + 8'd1)};

    function automatic access_t f_push(input logic [15:0] ad, input logic [7:0] d,
                                       input logic lst);
        access_t a;
        a.we      = 1'b1;
        a.sp_mode = SP_DEC;
        a.addr    = ad;
        a.wdata   = d;
        a.dst     = DST_NONE;
        a.last    = lst;
        return a;
    endfunction

    function automatic access_t f_read(input logic [15:0] ad, input sp_mode_e m,
                                       input dst_e dt, input logic lst);
        access_t a;
        a.we      = 1'b0;
        a.sp_mode = m;
        a.addr    = ad;
        a.wdata   = 8'h00;
        a.dst     = dt;
        a.last    = lst;
        return a;
    endfunction

    always_comb begin
        acc_o = '0;
        unique case (op)
            OP_CALL: begin
                if (step == 0) acc_o = f_push(push_addr, ret_addr[15:8], 1'b0);
                else           acc_o = f_push(push_addr, ret_addr[7:0], 1'b1);
            end
            OP_RET: begin
                if (step == 0) acc_o = f_read(pull_addr, SP_INC, DST_LO, 1'b0);
                else           acc_o = f_read(pull_addr, SP_INC, DST_HI, 1'b1);
            end
            OP_BRK: begin
                case (step)
                    STEP_W'(0): acc_o = f_push(push_addr, ret_addr[15:8], 1'b0);
                    STEP_W'(1): acc_o = f_push(push_addr, ret_addr[7:0], 1'b0);
                    STEP_W'(2): acc_o = f_push(push_addr, st | (8'h01 << FLAG_B), 1'b0);
                    STEP_W'(3): acc_o = f_read(VEC_ADDR, SP_HOLD, DST_LO, 1'b0);
                    default:    acc_o = f_read(VEC_HI_ADDR, SP_HOLD, DST_HI, 1'b1);
                endcase
            end
            OP_RTI: begin
                case (step)
                    STEP_W'(0): acc_o = f_read(pull_addr, SP_INC, DST_ST, 1'b0);
                    STEP_W'(1): acc_o = f_read(pull_addr, SP_INC, DST_LO, 1'b0);
                    default:    acc_o = f_read(pull_addr, SP_INC, DST_HI, 1'b1);
                endcase
            end
            OP_PUSHA: acc_o = f_push(push_addr, acc, 1'b1);
            OP_PULLA: acc_o = f_read(pull_addr, SP_INC, DST_ACC, 1'b1);
            OP_PUSHS: acc_o = f_push(push_addr, st & ~(8'h01 << FLAG_B), 1'b1);
            default:  acc_o = f_read(pull_addr, SP_INC, DST_ST, 1'b1);
        endcase
    end

endmodule

// File: rtl/stack_seq.sv
module stack_seq
    import stack_seq_pkg::*;
#(
    parameter logic [7:0]  PAGE     = 8'h01,
    parameter logic [15:0] VEC_ADDR = 16'hFFFE,
    parameter logic [7:0]  SP_RESET = 8'hFF
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [2:0]  op,
    input  logic [15:0] pc_in,
    input  logic [7:0]  status_in,
    input  logic [7:0]  acc_in,
    input  logic [15:0] target_in,
    output logic        mem_req,
    output logic        mem_we,
    output logic [15:0] mem_addr,
    output logic [7:0]  mem_wdata,
    input  logic [7:0]  mem_rdata,
    input  logic        mem_ready,
    output logic [15:0] pc_out,
    output logic [7:0]  status_out,
    output logic [7:0]  acc_out,
    output logic [7:0]  sp_out,
    output logic        busy,
    output logic        done
);

    typedef struct packed {
        logic              busy;
        seq_op_e           op;
        logic [STEP_W-1:0] step;
        logic [7:0]        sp;
        logic [15:0]       ctx_pc;
        logic [7:0]        ctx_st;
        logic [7:0]        ctx_acc;
        logic [7:0]        lo;
        logic [15:0]       res_pc;
        logic [7:0]        res_st;
        logic [7:0]        res_acc;
        logic              done;
    } state_t;

    localparam state_t RESET_STATE = '{
        busy: 1'b0, op: OP_CALL, step: '0, sp: SP_RESET,
        ctx_pc: '0, ctx_st: '0, ctx_acc: '0, lo: '0,
        res_pc: '0, res_st: '0, res_acc: '0, done: 1'b0
    };

    localparam logic [7:0] B_MASK = 8'h01 << FLAG_B;
    localparam logic [7:0] I_MASK = 8'h01 << FLAG_I;

    state_t  st_q, st_d;
    access_t cur;
    seq_op_e op_sel;

    assign op_sel = seq_op_e'(op);

    stack_seq_step #(
        .PAGE     (PAGE),
        .VEC_ADDR (VEC_ADDR)
    ) u_step (
        .op    (st_q.op),
        .step  (st_q.step),
        .sp    (st_q.sp),
        .pc    (st_q.ctx_pc),
        .st    (st_q.ctx_st),
        .acc   (st_q.ctx_acc),
        .acc_o (cur)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.busy) begin
            if (start) begin
                st_d.busy    = 1'b1;
                st_d.op      = op_sel;
                st_d.step    = '0;
                st_d.ctx_pc  = pc_in;
                st_d.ctx_st  = status_in;
                st_d.ctx_acc = acc_in;
                st_d.res_pc  = (op_sel == OP_CALL) ? target_in : pc_in;
                st_d.res_st  = (op_sel == OP_BRK) ? (status_in | B_MASK | I_MASK) : status_in;
                st_d.res_acc = acc_in;
            end
        end else if (mem_ready) begin
            case (cur.sp_mode)
                SP_DEC:  st_d.sp = st_q.sp - 8'd1;
                SP_INC:  st_d.sp = st_q.sp + 8'd1;
                default: st_d.sp = st_q.sp;
            endcase
            case (cur.dst)
                DST_LO:  st_d.lo = mem_rdata;
                DST_HI:  st_d.res_pc = {mem_rdata, st_q.lo} + ((st_q.op == OP_RET) ? 16'd1 : 16'd0);
                DST_ST:  st_d.res_st = (st_q.op == OP_PULLS) ? (mem_rdata & ~B_MASK) : mem_rdata;
                DST_ACC: begin
                    st_d.res_acc        = mem_rdata;
                    st_d.res_st[FLAG_N] = mem_rdata[7];
                    st_d.res_st[FLAG_Z] = (mem_rdata == 8'h00);
                end
                default: ;
            endcase
            if (cur.last) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end else begin
                st_d.step = st_q.step + STEP_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= RESET_STATE;
        else        st_q <= st_d;
    end

    assign mem_req    = st_q.busy;
    assign mem_we     = st_q.busy & cur.we;
    assign mem_addr   = st_q.busy ? cur.addr : 16'h0000;
    assign mem_wdata  = st_q.busy ? cur.wdata : 8'h00;
    assign pc_out     = st_q.res_pc;
    assign status_out = st_q.res_st;
    assign acc_out    = st_q.res_acc;
    assign sp_out     = st_q.sp;
    assign busy       = st_q.busy;
    assign done       = st_q.done;

    // R2
    push_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_we |-> mem_addr == {PAGE, sp_out});

    // R2
    push_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_ready && mem_we |=> sp_out == 8'($past(sp_out) - 8'd1));

    // R2
    pull_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && mem_ready && !mem_we && (mem_addr[15:8] == PAGE)
        |=> sp_out == 8'($past(sp_out) + 8'd1));

    // R11
    hold_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && !mem_ready |=> mem_req && $stable(mem_addr) && $stable(mem_we)
                                  && $stable(mem_wdata));

    // R12
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5
    vector_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req && (mem_addr[15:1] == VEC_ADDR[15:1]) |-> !mem_we && st_q.op == OP_BRK);

    // R13
    busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && start && !mem_ready |=> busy && st_q.op == $past(st_q.op)
                                        && st_q.step == $past(st_q.step));

endmodule

// File: tb/stack_seq_tb.sv
`timescale 1ns/1ps
module stack_seq_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  op = 3'd0;
    logic [15:0] pc_in = '0;
    logic [7:0]  status_in = '0;
    logic [7:0]  acc_in = '0;
    logic [15:0] target_in = '0;
    logic        mem_req, mem_we;
    logic [15:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata;
    logic        mem_ready = 1'b1;
    logic [15:0] pc_out;
    logic [7:0]  status_out, acc_out, sp_out;
    logic        busy, done;

    int checks = 0;
    int fails  = 0;
    int acc_cnt = 0;
    bit rand_rdy = 1'b0;
    bit finished = 1'b0;

    logic [7:0] stk [256];
    logic [7:0] vec_lo = 8'h34;
    logic [7:0] vec_hi = 8'hE0;
    logic [7:0] m_sp = 8'hFF;

    always #10 clk = ~clk;

    stack_seq u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op), .pc_in(pc_in),
        .status_in(status_in), .acc_in(acc_in), .target_in(target_in),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ready(mem_ready), .pc_out(pc_out),
        .status_out(status_out), .acc_out(acc_out), .sp_out(sp_out),
        .busy(busy), .done(done)
    );

    assign mem_rdata = (mem_addr[15:8] == 8'h01) ? stk[mem_addr[7:0]] :
                       (mem_addr == 16'hFFFE) ? vec_lo :
                       (mem_addr == 16'hFFFF) ? vec_hi : 8'h00;

    always @(posedge clk) begin
        if (mem_req && mem_ready) begin
            acc_cnt <= acc_cnt + 1;
            if (mem_we && mem_addr[15:8] == 8'h01) stk[mem_addr[7:0]] <= mem_wdata;
        end
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // ready driver and stall monitor (R11)
    bit          stall_prev = 1'b0;
    logic [15:0] s_addr;
    logic        s_we;
    logic [7:0]  s_wdata;
    always @(negedge clk) begin
        logic r_new;
        if (stall_prev) begin
            checks++;
            if (!mem_req || mem_addr !== s_addr || mem_we !== s_we || mem_wdata !== s_wdata) begin
                fails++;
                $display("FAIL R11 stalled access moved actual=%h expected=%h", mem_addr, s_addr);
            end
        end
        r_new = rand_rdy ? (($urandom % 4) != 0) : 1'b1;
        stall_prev = mem_req && !r_new;
        s_addr = mem_addr;
        s_we = mem_we;
        s_wdata = mem_wdata;
        mem_ready <= r_new;
    end

    function automatic string tag_of(input logic [2:0] o);
        case (o)
            3'd0: return "R3";
            3'd1: return "R4";
            3'd2: return "R5";
            3'd3: return "R6";
            3'd4: return "R7";
            3'd5: return "R8";
            3'd6: return "R9";
            default: return "R10";
        endcase
    endfunction

    function automatic int n_access(input logic [2:0] o);
        case (o)
            3'd0, 3'd1: return 2;
            3'd2: return 5;
            3'd3: return 3;
            default: return 1;
        endcase
    endfunction

    task automatic run_op(input logic [2:0] o, input logic [15:0] pc, input logic [7:0] st,
                          input logic [7:0] ac, input logic [15:0] tgt, input bit inject);
        logic [15:0] e_pc, r;
        logic [7:0]  e_st, e_acc, s0, v;
        logic [7:0]  w_addr [3];
        logic [7:0]  w_exp  [3];
        int nw;
        int n0;
        string t;
        t = tag_of(o);
        s0 = m_sp;
        e_pc = pc; e_st = st; e_acc = ac; nw = 0;
        r = pc + 16'd2;
        case (o)
            3'd0: begin
                w_addr[0] = s0; w_exp[0] = r[15:8];
                w_addr[1] = 8'(s0 - 1); w_exp[1] = r[7:0];
                nw = 2; m_sp = 8'(s0 - 2); e_pc = tgt;
            end
            3'd1: begin
                e_pc = {stk[8'(s0 + 2)], stk[8'(s0 + 1)]} + 16'd1;
                m_sp = 8'(s0 + 2);
            end
            3'd2: begin
                w_addr[0] = s0; w_exp[0] = r[15:8];
                w_addr[1] = 8'(s0 - 1); w_exp[1] = r[7:0];
                w_addr[2] = 8'(s0 - 2); w_exp[2] = st | 8'h10;
                nw = 3; m_sp = 8'(s0 - 3);
                e_pc = {vec_hi, vec_lo}; e_st = st | 8'h14;
            end
            3'd3: begin
                e_st = stk[8'(s0 + 1)];
                e_pc = {stk[8'(s0 + 3)], stk[8'(s0 + 2)]};
                m_sp = 8'(s0 + 3);
            end
            3'd4: begin
                w_addr[0] = s0; w_exp[0] = ac; nw = 1; m_sp = 8'(s0 - 1);
            end
            3'd5: begin
                v = stk[8'(s0 + 1)];
                e_acc = v;
                e_st = (st & 8'h7D) | {v[7], 5'd0, (v == 8'h00), 1'b0};
                m_sp = 8'(s0 + 1);
            end
            3'd6: begin
                w_addr[0] = s0; w_exp[0] = st & 8'hEF; nw = 1; m_sp = 8'(s0 - 1);
            end
            default: begin
                e_st = stk[8'(s0 + 1)] & 8'hEF;
                m_sp = 8'(s0 + 1);
            end
        endcase
        @(negedge clk);
        n0 = acc_cnt;
        start = 1'b1; op = o; pc_in = pc; status_in = st; acc_in = ac; target_in = tgt;
        @(negedge clk);
        start = 1'b0;
        if (inject) begin
            // R13: second request while busy must be ignored
            start = 1'b1; op = 3'd4; acc_in = ~ac;
            @(negedge clk);
            start = 1'b0;
        end
        for (int i = 0; i < 200 && !done; i++) @(negedge clk);
        chk({t, " R12 done"}, {15'd0, done}, 16'd1);
        chk({t, " pc"}, pc_out, e_pc);
        chk({t, " status"}, {8'd0, status_out}, {8'd0, e_st});
        chk({t, " acc"}, {8'd0, acc_out}, {8'd0, e_acc});
        chk({t, " R2 sp"}, {8'd0, sp_out}, {8'd0, m_sp});
        chk({t, " R11 access count"}, 16'(acc_cnt - n0), 16'(n_access(o)));
        for (int k = 0; k < nw; k++)
            chk({t, " R2 stack byte"}, {8'd0, stk[w_addr[k]]}, {8'd0, w_exp[k]});
        @(negedge clk);
        chk("R12 done width", {15'd0, done}, 16'd0);
        if (inject) begin
            repeat (3) begin
                @(negedge clk);
                chk("R13 no extra activity", {14'd0, done, mem_req}, 16'd0);
            end
            chk("R13 sp unchanged", {8'd0, sp_out}, {8'd0, m_sp});
        end
    endtask

    initial begin
        void'($urandom(32'h5EED));
        for (int i = 0; i < 256; i++) stk[i] = 8'($urandom);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 sp", {8'd0, sp_out}, 16'h00FF);
        chk("R1 pc", pc_out, 16'h0000);
        chk("R1 status/acc", {status_out, acc_out}, 16'h0000);
        chk("R1 idle", {13'd0, mem_req, busy, done}, 16'd0);

        // R2 wrap: pull from SP=FF reads 0x0100
        stk[0] = 8'h00;
        run_op(3'd5, 16'h1000, 8'h80, 8'h55, 16'h0, 1'b0); // R8 zero byte sets bit 1
        chk("R2 wrap sp", {8'd0, sp_out}, 16'h0000);
        run_op(3'd4, 16'h1000, 8'h00, 8'hA5, 16'h0, 1'b0); // R7 push back to 0x0100
        chk("R2 wrap push", {8'd0, stk[0]}, 16'h00A5);
        // directed: call/return pair, R4 +1 across page
        run_op(3'd0, 16'h12FE, 8'h30, 8'h11, 16'hC000, 1'b0); // R3
        run_op(3'd1, 16'hC010, 8'h30, 8'h11, 16'h0, 1'b0);    // R4 -> 0x1301
        chk("R4 return address", pc_out, 16'h1301);
        // break then return from interrupt
        run_op(3'd2, 16'h2000, 8'h01, 8'h00, 16'h0, 1'b0);    // R5
        run_op(3'd3, 16'hE034, 8'h14, 8'h00, 16'h0, 1'b0);    // R6 keeps bit 4
        chk("R6 status with break bit", {8'd0, status_out}, 16'h0011);
        chk("R6 pc", pc_out, 16'h2002);
        // status push/pull masking
        run_op(3'd6, 16'h3000, 8'hFF, 8'h00, 16'h0, 1'b0);    // R9
        run_op(3'd7, 16'h3000, 8'h00, 8'h00, 16'h0, 1'b0);    // R10
        chk("R10 pulled status", {8'd0, status_out}, 16'h00EF);
        // R13 injection during a break
        run_op(3'd2, 16'h4000, 8'h00, 8'h77, 16'h0, 1'b1);
        // random mix with stalls
        rand_rdy = 1'b1;
        for (int n = 0; n < 150; n++)
            run_op(3'($urandom), 16'($urandom), 8'($urandom), 8'($urandom), 16'($urandom),
                   (($urandom % 8) == 0));
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=complete");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule